// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block is an output-stage counter that turns a fast input clock into a slower clock. The output stays high for a programmed number of input cycles and then low for a second programmed number. The sum of the two counts is the divide ratio. Their ratio to each other sets the duty cycle, in steps of one input cycle. Equal counts give a 50% clock.

New counts can be loaded at any time. They are held back until the next rising edge of the output, so a period is never cut short. A bypass select routes the input clock straight to the output, which gives divide-by-one.

In cascade mode the counter advances only on rising edges of a cascade input, so the clock output of an upstream divider can drive this one and the two ratios multiply. Both count fields use an 8-bit code in which 0 stands for 256.

Top module: `progDutyDivider`

## Requirements
- R1: While rstN is low, clkOut is low. After reset the output rises on the first advancing edge, that is, the first rising clk edge with enable high (and, in cascade mode, with a cascade rising edge).
- R2: After each rise, clkOut stays high for exactly the decoded high count of advancing edges. A highCount code of 1..255 means that many cycles, and code 0 means 256.
- R3: After each fall, clkOut stays low for exactly the decoded low count of advancing edges, with the same encoding as R2 (code 0 means 256).
- R4: The output period equals the decoded high count plus the decoded low count. Equal codes give a 50% duty cycle, and codes 1/1 give divide-by-2.
- R5: An edge with enable low does not advance the counter. clkOut and the phase position hold until enable returns.
- R6: A rising clk edge with load high captures highCount and lowCount, whether or not enable is high. The captured values take effect only at the next rise of the output, and the period in progress finishes with the old counts.
- R7: With bypass high, clkOut equals clk: high while clk is high and low while clk is low. The counter keeps its state while bypassed.
- R8: With cascadeSel high, the counter advances only on a clk edge where cascadeIn is high and was low at the previous clk edge. A downstream divider therefore counts the upstream output's rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counting enable |
| load | input | 1 | Capture strobe for the count fields |
| highCount | input | CNT_W | High-time code (0 means 2^CNT_W) |
| lowCount | input | CNT_W | Low-time code (0 means 2^CNT_W) |
| bypass | input | 1 | Pass clk straight to clkOut |
| cascadeSel | input | 1 | Advance on cascadeIn rising edges only |
| cascadeIn | input | 1 | Clock from an upstream divider |
| clkOut | output | 1 | Divided (or bypassed) clock |

## Verification
Several kinds of pattern are tried.
- Unequal counts (3/5) show whether the high and low fields are swapped.
- Equal counts (4/4) and the minimum pair (1/1) confirm the 50% setting and divide-by-2.
- The pairs 256/1 and 1/256, both written as code 0, separate correct decoding of the wrap code from a literal zero.
- A load in the middle of a high phase, a stretch with enable toggling, and a gated cascade input each show whether an update or a pause disturbs the period in progress.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Per-edge action chosen by the control and applied by the datapath
  typedef struct packed {
    logic rise;   // start a high phase, apply pending counts
    logic fall;   // start a low phase
    logic dec;    // count down inside the current phase
  } divStrobe_t;

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       cascadeSel,
  input  logic       cascadeIn,
  input  logic       level,
  input  logic       remIsOne,
  input  logic       remIsZero,
  output divStrobe_t strobe
);

  logic cascPrev;
  logic cascEdge;
  logic advance;
  logic phaseDone;

  // Previous cascade level, sampled on every edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cascPrev <= 1'b0;
    else       cascPrev <= cascadeIn;
  end

  assign cascEdge  = cascadeIn & ~cascPrev;
  assign advance   = enable & (cascadeSel ? cascEdge : 1'b1);
  assign phaseDone = remIsOne | remIsZero;

  always_comb begin
    strobe.rise = advance & ~level & phaseDone;
    strobe.fall = advance &  level & remIsOne;
    strobe.dec  = advance & ~strobe.rise & ~strobe.fall;
  end

endmodule

// File: rtl/divPath.sv
module divPath
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [CNT_W-1:0] highCode,
  input  logic [CNT_W-1:0] lowCode,
  input  divStrobe_t       strobe,
  output logic             level,
  output logic             remIsOne,
  output logic             remIsZero,
  output logic [CNT_W-1:0] activeHigh,
  output logic [CNT_W-1:0] activeLow
);

  localparam int REM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CODE_ONE = CNT_W'(1);

  logic [CNT_W-1:0] pendHigh;
  logic [CNT_W-1:0] pendLow;
  logic [REM_W-1:0] remaining;

  // Code 0 stands for the full range 2^CNT_W
  function automatic logic [REM_W-1:0] expand(input logic [CNT_W-1:0] code);
    expand = {(code == '0), code};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendHigh <= CODE_ONE;
      pendLow  <= CODE_ONE;
    end else if (load) begin
      pendHigh <= highCode;
      pendLow  <= lowCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeHigh <= CODE_ONE;
      activeLow  <= CODE_ONE;
      remaining  <= '0;
      level      <= 1'b0;
    end else begin
      if (strobe.rise) begin
        activeHigh <= pendHigh;
        activeLow  <= pendLow;
        remaining  <= expand(pendHigh);
        level      <= 1'b1;
      end else if (strobe.fall) begin
        remaining  <= expand(activeLow);
        level      <= 1'b0;
      end else if (strobe.dec) begin
        remaining  <= remaining - REM_W'(1);
      end
    end
  end

  assign remIsOne  = (remaining == REM_W'(1));
  assign remIsZero = (remaining == '0);

endmodule

// File: rtl/progDutyDivider.sv
module progDutyDivider
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             load,
  input  logic [CNT_W-1:0] highCount,
  input  logic [CNT_W-1:0] lowCount,
  input  logic             bypass,
  input  logic             cascadeSel,
  input  logic             cascadeIn,
  output logic             clkOut
);

  divStrobe_t       strobe;
  logic             divLevel;
  logic             remIsOne;
  logic             remIsZero;
  logic [CNT_W-1:0] activeHigh;
  logic [CNT_W-1:0] activeLow;

  divCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cascadeSel (cascadeSel),
    .cascadeIn  (cascadeIn),
    .level      (divLevel),
    .remIsOne   (remIsOne),
    .remIsZero  (remIsZero),
    .strobe     (strobe)
  );

  divPath #(.CNT_W(CNT_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .load       (load),
    .highCode   (highCount),
    .lowCode    (lowCount),
    .strobe     (strobe),
    .level      (divLevel),
    .remIsOne   (remIsOne),
    .remIsZero  (remIsZero),
    .activeHigh (activeHigh),
    .activeLow  (activeLow)
  );

  assign clkOut = bypass ? clk : divLevel;

endmodule

// File: rtl/progDutyDividerChk.sv
module progDutyDividerChk
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             cascadeSel,
  input logic             cascadeIn,
  input logic             level,
  input divStrobe_t       strobe,
  input logic [CNT_W-1:0] activeHigh,
  input logic [CNT_W-1:0] activeLow
);

  localparam int REM_W = CNT_W + 1;

  logic [REM_W-1:0] runLen;
  logic             seenRise;
  logic [REM_W-1:0] hiLen;
  logic [REM_W-1:0] loLen;

  assign hiLen = {(activeHigh == '0), activeHigh};
  assign loLen = {(activeLow == '0), activeLow};

  // Advancing edges since the last output transition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen   <= '0;
      seenRise <= 1'b0;
    end else begin
      if (strobe.rise || strobe.fall) runLen <= REM_W'(1);
      else if (strobe.dec)            runLen <= runLen + REM_W'(1);
      if (strobe.rise) seenRise <= 1'b1;
    end
  end

  a_r2_high_len: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fall |-> runLen == hiLen);

  a_r3_low_len: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rise && seenRise) |-> runLen == loLen);

  a_r4_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rise, strobe.fall, strobe.dec}));

  a_r5_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(level));

  a_r8_cascade_wait: assert property (@(posedge clk) disable iff (!rstN)
    (cascadeSel && !cascadeIn) |=> $stable(level));

  always @(negedge clk) begin
    if (!rstN) a_r1_reset_low: assert (!level);
  end

endmodule

bind progDutyDivider progDutyDividerChk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .cascadeSel (cascadeSel),
  .cascadeIn  (cascadeIn),
  .level      (divLevel),
  .strobe     (strobe),
  .activeHigh (activeHigh),
  .activeLow  (activeLow)
);

// File: tb/test_progDutyDivider.sv
`timescale 1ns/1ps
module test_progDutyDivider;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       load = 1'b0;
  logic [7:0] highCount = 8'd1;
  logic [7:0] lowCount = 8'd1;
  logic       bypass = 1'b0;
  logic       cascadeSel = 1'b0;
  logic       cascadeIn = 1'b0;
  logic       clkOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  progDutyDivider i_progDutyDivider (
    .clk(clk), .rstN(rstN), .enable(enable), .load(load),
    .highCount(highCount), .lowCount(lowCount), .bypass(bypass),
    .cascadeSel(cascadeSel), .cascadeIn(cascadeIn), .clkOut(clkOut)
  );

  // Behavioural reference model
  int mLvl, mRem, mPH, mPL, mAH, mAL, mCPrev;

  function automatic int full(input logic [7:0] c);
    return (c == 0) ? 256 : int'(c);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLvl = 0; mRem = 0; mPH = 1; mPL = 1; mAH = 1; mAL = 1; mCPrev = 0;
    end else begin
      bit adv;
      adv = enable && (cascadeSel ? (cascadeIn && mCPrev == 0) : 1'b1);
      mCPrev = cascadeIn;
      if (adv) begin
        if (mLvl == 0 && mRem <= 1) begin
          mLvl = 1; mAH = mPH; mAL = mPL; mRem = mAH;
        end else if (mLvl == 1 && mRem == 1) begin
          mLvl = 0; mRem = mAL;
        end else begin
          mRem = mRem - 1;
        end
      end
      if (load) begin
        mPH = full(highCount); mPL = full(lowCount);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare with the model on every clock, away from the rising edge
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      int expOut;
      expOut = bypass ? 0 : mLvl;
      check(clkOut === expOut[0], curReq, int'(clkOut), expOut);
    end
  end

  always @(negedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic setCounts(input logic [7:0] h, input logic [7:0] l);
    @(negedge clk); #1;
    highCount = h; lowCount = l; load = 1'b1;
    @(negedge clk); #1;
    load = 1'b0;
  endtask

  task automatic measure(input int expH, input int expL, input string req);
    int h, l;
    @(negedge clk);
    while (clkOut !== 1'b0) @(negedge clk);
    while (clkOut !== 1'b1) @(negedge clk);
    h = 0;
    while (clkOut === 1'b1) begin h++; @(negedge clk); end
    l = 0;
    while (clkOut === 1'b0) begin l++; @(negedge clk); end
    check(h == expH, {req, " high length"}, h, expH);
    check(l == expL, {req, " low length"}, l, expL);
    check(h + l == expH + expL, "R4 period", h + l, expH + expL);
  endtask

  initial begin
    // R1: reset keeps the output low
    curReq = "R1";
    step(4);
    check(clkOut === 1'b0, "R1 reset level", int'(clkOut), 0);
    rstN = 1'b1;
    // R5: held while enable is low; R6: load captured while disabled
    curReq = "R5";
    step(3);
    check(clkOut === 1'b0, "R5 idle before enable", int'(clkOut), 0);
    setCounts(8'd3, 8'd5);
    curReq = "R1";
    enable = 1'b1;
    @(posedge clk); #1;
    check(clkOut === 1'b1, "R1 first enabled edge rises", int'(clkOut), 1);
    curReq = "R2";
    measure(3, 5, "R2");
    // R4: 50% duty
    curReq = "R4";
    setCounts(8'd4, 8'd4);
    measure(4, 4, "R4");
    setCounts(8'd1, 8'd1);
    measure(1, 1, "R4");
    // R2 / R3: code 0 means 256
    curReq = "R2";
    setCounts(8'd0, 8'd1);
    measure(256, 1, "R2");
    curReq = "R3";
    setCounts(8'd1, 8'd0);
    measure(1, 256, "R3");
    // R6: load in the middle of a high phase
    curReq = "R6";
    setCounts(8'd6, 8'd2);
    @(negedge clk);
    while (clkOut !== 1'b1) @(negedge clk);
    step(2);
    highCount = 8'd2; lowCount = 8'd3; load = 1'b1;
    step(1);
    load = 1'b0;
    while (clkOut !== 1'b0) @(negedge clk);
    begin
      int l;
      l = 0;
      while (clkOut === 1'b0) begin l++; @(negedge clk); end
      check(l == 2, "R6 old low count kept", l, 2);
    end
    measure(2, 3, "R6");
    // R5: enable toggling
    curReq = "R5";
    setCounts(8'd3, 8'd2);
    for (int i = 0; i < 12; i++) begin
      enable = i[0];
      step(3);
    end
    enable = 1'b1;
    step(10);
    // R7: bypass
    curReq = "R7";
    bypass = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      check(clkOut === 1'b1, "R7 bypass high", int'(clkOut), 1);
      @(negedge clk); #1;
      check(clkOut === 1'b0, "R7 bypass low", int'(clkOut), 0);
    end
    bypass = 1'b0;
    step(4);
    // R8: cascade, advance on cascadeIn rising edges
    curReq = "R8";
    setCounts(8'd2, 8'd2);
    cascadeSel = 1'b1;
    for (int i = 0; i < 30; i++) begin
      cascadeIn = ~cascadeIn;
      step(3);
    end
    cascadeSel = 1'b0;
    cascadeIn = 1'b0;
    step(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule